// File: doc/BRIEF.md
# Delta Varint Trace Encoder

This block turns a stream of memory-access trace records into a compact byte stream. Each record carries a 32-bit address, a 64-bit timestamp and a flag saying whether the access hit. For every record it keeps, the block subtracts the previously kept address and timestamp. It then emits two variable-length integers: first the signed address difference, then the unsigned time difference.

The signed address difference is zigzag-mapped so that small negative steps stay short. Each integer is cut into 7-bit groups, least significant group first. Bit 7 of every byte is set except on the final byte of that integer.

Records enter on a valid/ready handshake, and bytes leave on a byte-wide valid/ready handshake. Two inputs filter the stream. Misses are encoded whenever tracing is enabled. Hits are encoded only when the trace-all input is also set. A filtered record is still accepted, but it emits nothing and leaves the running previous values untouched. The previous address and time are never cleared except by reset.

Top module: `trc_delta_encoder`

## Requirements
- R1: After reset, byte_valid is 0, rec_ready is 1, and the previous address and previous time both start at zero, so the first kept record is encoded against zero.
- R2: The address field is d = (addr - prev_addr) mod 2^32, read as signed. It is mapped to z = (d << 1) XOR (32 copies of bit 31 of d) before encoding.
- R3: The time field is (time - prev_time) mod 2^64, treated as unsigned, so a timestamp that goes backwards wraps.
- R4: Each field is sent as 7-bit groups, least significant first. Bits 6:0 hold the group and bit 7 is 1 on every byte except the last byte of that field. A zero value is the single byte 0x00. A 32-bit field takes at most 5 bytes and a 64-bit field at most 10 bytes.
- R5: All bytes of a record's address field leave before any byte of its time field, and records leave in arrival order.
- R6: After each kept record, the previous address and time take that record's values. They persist across any number of later records.
- R7: A record is kept when trace_en is 1 and either rec_hit is 0 or trace_all is 1. A record that is not kept is accepted, emits no byte, and leaves the previous values unchanged.
- R8: rec_ready is 0 whenever byte_valid is 1, so a new record is taken only after every byte of the current record has been sent.
- R9: While byte_valid is 1 and byte_ready is 0, byte_valid stays 1 and byte_data holds its value in the next cycle.
- R10: In the cycle right after a kept record is accepted, byte_valid is 1. In the cycle right after a filtered record is accepted, byte_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Enables encoding of miss records |
| trace_all | input | 1 | When also set, hit records are encoded too |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Record taken this cycle if rec_valid |
| rec_addr | input | 32 | Record address |
| rec_time | input | 64 | Record timestamp |
| rec_hit | input | 1 | 1 if the access hit |
| byte_valid | output | 1 | Output byte offered |
| byte_ready | input | 1 | Sink takes the byte this cycle |
| byte_data | output | 8 | Encoded byte |

## Verification
A kept record accepted at a clock edge must show its first byte after that same edge. Each later byte follows the edge at which the previous byte was taken. rec_ready only returns after the edge that takes the final time byte. The bench therefore drives inputs and reads outputs on the falling edge. It adds a record's expected bytes to a queue when it sees rec_ready high with rec_valid asserted, and it removes and compares one byte at every falling edge where byte_valid and byte_ready are both high. A stalled byte is compared against itself one cycle later, and the R10 check looks at byte_valid exactly one falling edge after the acceptance edge.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int ADDR_W = 32;
    localparam int TIME_W = 64;
    localparam int GRP_W  = 7;
    localparam int BYTE_W = GRP_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TIME_W-1:0] time_t;

    typedef struct packed {
        addr_t zz_addr;
        time_t d_time;
    } delta_t;

    function automatic addr_t zigzag(input addr_t d);
        return {d[ADDR_W-2:0], 1'b0} ^ {ADDR_W{d[ADDR_W-1]}};
    endfunction

    function automatic int groups_for(input int w);
        return (w + GRP_W - 1) / GRP_W;
    endfunction
endpackage

// File: rtl/trc_delta.sv
module trc_delta
    import trc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   trace_en,
    input  logic   trace_all,
    input  logic   accept,
    input  addr_t  cur_addr,
    input  time_t  cur_time,
    input  logic   cur_hit,
    output logic   keep,
    output delta_t delta
);
    addr_t prev_addr_q;
    time_t prev_time_q;
    addr_t raw_addr_diff;

    assign keep          = trace_en && (!cur_hit || trace_all);
    assign raw_addr_diff = cur_addr - prev_addr_q;
    assign delta.zz_addr = zigzag(raw_addr_diff);
    assign delta.d_time  = cur_time - prev_time_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr_q <= '0;
            prev_time_q <= '0;
        end else if (accept && keep) begin
            prev_addr_q <= cur_addr;
            prev_time_q <= cur_time;
        end
    end

    AST_PREV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(accept && keep) |=> ($stable(prev_addr_q) && $stable(prev_time_q))); // R6
    AST_PREV_LOAD: assert property (@(posedge clk) disable iff (rst)
        (accept && keep) |=> (prev_addr_q == $past(cur_addr) && prev_time_q == $past(cur_time))); // R6
endmodule

// File: rtl/trc_varint_ser.sv
module trc_varint_ser
    import trc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [W-1:0]      load_val,
    input  logic              take,
    output logic              busy,
    output logic [BYTE_W-1:0] out_byte
);
    localparam int NB    = groups_for(W);
    localparam int CNT_W = $clog2(NB + 1);

    logic [W-1:0]     val_q;
    logic [W-1:0]     rest;
    logic             busy_q;
    logic             last;
    logic [CNT_W-1:0] sent_q;

    assign rest     = val_q >> GRP_W;
    assign last     = (rest == '0);
    assign busy     = busy_q;
    assign out_byte = {~last, val_q[GRP_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q  <= '0;
            busy_q <= 1'b0;
            sent_q <= '0;
        end else if (load) begin
            val_q  <= load_val;
            busy_q <= 1'b1;
            sent_q <= '0;
        end else if (take && busy_q) begin
            val_q  <= rest;
            sent_q <= sent_q + 1'b1;
            if (last) begin
                busy_q <= 1'b0;
            end
        end
    end

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (sent_q < CNT_W'(NB))); // R4
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy_q); // R8
    AST_FINAL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (busy_q && take && !out_byte[BYTE_W-1] && !load) |=> !busy_q); // R4
endmodule

// File: rtl/trc_delta_encoder.sv
module trc_delta_encoder
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trace_en,
    input  logic              trace_all,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [TIME_W-1:0] rec_time,
    input  logic              rec_hit,
    output logic              byte_valid,
    input  logic              byte_ready,
    output logic [BYTE_W-1:0] byte_data
);
    logic              accept;
    logic              keep;
    logic              start;
    delta_t            delta;
    logic              a_busy, t_busy;
    logic [BYTE_W-1:0] a_byte, t_byte;
    logic              take_a, take_t;
    logic              xfer;

    assign rec_ready  = !a_busy && !t_busy;
    assign accept     = rec_valid && rec_ready;
    assign start      = accept && keep;
    assign byte_valid = a_busy || t_busy;
    assign byte_data  = a_busy ? a_byte : t_byte;
    assign xfer       = byte_valid && byte_ready;
    assign take_a     = xfer && a_busy;
    assign take_t     = xfer && !a_busy;

    trc_delta u_delta (
        .clk       (clk),
        .rst       (rst),
        .trace_en  (trace_en),
        .trace_all (trace_all),
        .accept    (accept),
        .cur_addr  (rec_addr),
        .cur_time  (rec_time),
        .cur_hit   (rec_hit),
        .keep      (keep),
        .delta     (delta)
    );

    trc_varint_ser #(.W(ADDR_W)) u_addr_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (delta.zz_addr),
        .take     (take_a),
        .busy     (a_busy),
        .out_byte (a_byte)
    );

    trc_varint_ser #(.W(TIME_W)) u_time_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (delta.d_time),
        .take     (take_t),
        .busy     (t_busy),
        .out_byte (t_byte)
    );

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> !rec_ready); // R8
    AST_HOLD_WHILE_STALL: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data))); // R9
    AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (rst)
        start |=> byte_valid); // R10
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (accept && !keep) |=> !byte_valid); // R7
    AST_ADDR_BEFORE_TIME: assert property (@(posedge clk) disable iff (rst)
        a_busy |-> t_busy); // R5
endmodule

// File: tb/test_trc_delta_encoder.sv
module test_trc_delta_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trace_en = 1'b0, trace_all = 1'b0;
    logic        rec_valid = 1'b0, rec_hit = 1'b0;
    logic [31:0] rec_addr = '0;
    logic [63:0] rec_time = '0;
    logic        rec_ready, byte_valid;
    logic        byte_ready = 1'b1;
    logic [7:0]  byte_data;

    int n_checks = 0;
    int n_fail   = 0;
    int ready_mode = 0;
    logic [31:0] m_prev_addr = '0;
    logic [63:0] m_prev_time = '0;
    logic [7:0]  exp_q[$];
    int          tag_q[$];
    logic        was_stalled = 1'b0;
    logic [7:0]  stalled_byte = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    trc_delta_encoder i_trc_delta_encoder (
        .clk(clk), .rst(rst), .trace_en(trace_en), .trace_all(trace_all),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_addr(rec_addr),
        .rec_time(rec_time), .rec_hit(rec_hit), .byte_valid(byte_valid),
        .byte_ready(byte_ready), .byte_data(byte_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_varint(input logic [63:0] v, input int tag);
        logic [63:0] r = v;
        do begin
            logic [7:0] b;
            b = {1'b0, r[6:0]};
            r = r >> 7;
            if (r != 0) b[7] = 1'b1;
            exp_q.push_back(b);
            tag_q.push_back(tag);
        end while (r != 0);
    endtask

    // Byte monitor: falling edge, ready chosen first, then handshake judged
    always @(negedge clk) begin
        if (!rst) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            byte_ready = (ready_mode == 0) ? 1'b1 : lfsr[0] | lfsr[3];
            if (was_stalled) begin
                check(byte_valid && byte_data == stalled_byte, "R9",
                      {55'd0, byte_valid, byte_data}, {56'd1, stalled_byte});
            end
            if (byte_valid) begin
                check(!rec_ready, "R8", 64'(rec_ready), 64'd0);
            end
            if (byte_valid && byte_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", 64'(byte_data), 64'hFF);
                end else begin
                    logic [7:0] e;
                    int t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(byte_data == e, (t == 2) ? "R2/R4 addr field" : "R3/R4 time field",
                          64'(byte_data), 64'(e));
                end
            end
            was_stalled  = byte_valid && !byte_ready;
            stalled_byte = byte_data;
        end
    end

    task automatic send(input logic [31:0] a, input logic [63:0] t, input logic hit);
        bit kept;
        @(negedge clk);
        rec_valid = 1'b1; rec_addr = a; rec_time = t; rec_hit = hit;
        #1;
        while (!rec_ready) begin
            @(negedge clk);
            #1;
        end
        kept = trace_en && (!hit || trace_all);   // R7 filter rule
        if (kept) begin
            logic [31:0] d;
            logic [31:0] z;
            d = a - m_prev_addr;
            z = {d[30:0], 1'b0} ^ {32{d[31]}};
            push_varint(64'(z), 2);
            push_varint(t - m_prev_time, 3);
            m_prev_addr = a;
            m_prev_time = t;
        end
        @(negedge clk);
        #2;
        rec_valid = 1'b0;
        check(byte_valid == kept, kept ? "R10 kept" : "R7/R10 dropped",
              64'(byte_valid), 64'(kept));
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_q.size() != 0 || byte_valid) && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        #1;
        check(exp_q.size() == 0 && !byte_valid, "R5 drain", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(rec_ready == 1'b1 && byte_valid == 1'b0, "R1 reset", {62'd0, rec_ready, byte_valid}, 64'd2);
        trace_en = 1'b1;
        // R1: first record encodes against zero -> 00 00
        send(32'h0, 64'h0, 1'b0); drain();
        // R2: +64 -> zigzag 128 -> 80 01; R3 time 5
        send(32'h40, 64'd5, 1'b0); drain();
        // R2: -16 -> 31; R4 zero time delta -> 00
        send(32'h30, 64'd5, 1'b0); drain();
        // R2 extreme negative step, R3 large step
        send(32'h80000030, 64'h8000_0000_0000_0005, 1'b0); drain();
        // R3 wrap: time goes backwards
        send(32'h80000031, 64'd1, 1'b0); drain();
        // R7: tracing off -> dropped, previous kept
        trace_en = 1'b0;
        send(32'h1234, 64'd999, 1'b0); drain();
        trace_en = 1'b1;
        // R7: hit without trace_all dropped, with trace_all kept
        send(32'h5555, 64'd77, 1'b1); drain();
        trace_all = 1'b1;
        send(32'h5556, 64'd78, 1'b1); drain();
        trace_all = 1'b0;
        // R6 persists across back-to-back records with backpressure (R9)
        ready_mode = 1;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            logic [63:0] t;
            a = $urandom();
            if (i % 3 == 0) a = m_prev_addr + 32'($urandom_range(0, 40)) - 32'd20;
            t = {32'($urandom()), 32'($urandom())};
            if (i % 4 != 0) t = m_prev_time + 64'($urandom_range(0, 300));
            trace_en  = (i % 11) != 5;
            trace_all = (i % 2) == 0;
            send(a, t, (i % 5) == 1);
        end
        drain();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule